// File: doc/BRIEF.md
# Hot-Plug Command and Status Engine

This block models the command and status side of a hot-plug slot controller. Software writes a 32-bit command word through a single write strobe. The engine accepts the word only when it is idle. It then holds a busy flag for a number of cycles set at its `busy_cycles` input, and at the end it either applies the command or reports one error. A one-cycle completion pulse follows every accepted command, whether it succeeded or not.

A command word does one of two things. It can move one slot to a new power state, where the slot is addressed as its index plus one. Or it can set a new bus speed code. The engine keeps a 2-bit state for each slot and a 3-bit current bus speed. It samples a per-slot latch-open input and a per-slot card-present input when the command executes. The status word shows busy, the three error flags and the current speed. The host bus protocol is outside the block.

Top module: `hpc_cmd_engine`

## Requirements
- R1: After reset every slot reads disabled (code 11), the bus speed is 000, and status bits 19:16 are all 0.
- R2: An accepted write (`wr_en` while status bit 16 is 0) sets status bit 16 for exactly max(`busy_cycles`,1) cycles. A write presented while bit 16 is 1 is ignored and produces no completion.
- R3: When bit 16 falls, `cmd_done` is high for exactly one cycle, with or without an error. At most one of the error bits 17 (latch open), 18 (invalid command) and 19 (invalid speed) is set. The error bits hold until the next accepted write clears them.
- R4: A command with bit 6 clear is a slot command. Bits 15:8 hold the target (slot index + 1) and bits 1:0 hold the requested state: 01 power only, 10 enabled, 11 disabled. On success only the target slot changes, and `slot_state[2i+1:2i]` shows slot i.
- R5: A slot command whose target is 0 or greater than NUM_SLOTS, or whose state code is 00, sets bit 18 and leaves all state unchanged.
- R6: A slot command to a slot whose `mrl_open` input is 1 at execution sets bit 17 and leaves the slot unchanged.
- R7: A power-only or enable command to a slot whose `card_present` is 0 sets bit 18. A disable command to an empty slot succeeds.
- R8: A command with bit 6 set is a speed command. On success the code in bits 2:0 becomes the bus speed, which is shown on `bus_speed` and in status bits 2:0.
- R9: A speed command with a code above 100, or issued while any slot is enabled (10), sets bit 19 and leaves the speed unchanged. Code 100 with no enabled slot succeeds.
- R10: Slot-command checks are made in a fixed priority order: first a bad target or code 00 (bit 18), then latch open (bit 17), then an empty slot (bit 18).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 32 | Command word |
| busy_cycles | input | CNT_W | Busy duration for the next accepted command |
| mrl_open | input | NUM_SLOTS | Per-slot retention latch open |
| card_present | input | NUM_SLOTS | Per-slot card present |
| status | output | 32 | Bit 16 busy, bits 19:17 errors, bits 2:0 speed |
| slot_state | output | 2*NUM_SLOTS | Packed per-slot state codes |
| bus_speed | output | 3 | Current bus speed code |
| cmd_done | output | 1 | One-cycle completion pulse |

## Verification
The checker watches properties on every cycle. It checks that the error flags are mutually exclusive and that the completion pulse lines up with the fall of busy and lasts one cycle. It checks that slot state and speed change only on a completion edge, that an errored completion changes nothing, and that the speed code never leaves its legal range. The bench scenarios are needed for the rest, because it depends on the command contents: the exact busy length, the choice of error, the priority order, the writes that are ignored while busy, and the value each success writes.

// File: rtl/hpc_cmd_engine.sv
module hpc_cmd_engine #(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [31:0]            wr_data,
  input  logic [CNT_W-1:0]       busy_cycles,
  input  logic [NUM_SLOTS-1:0]   mrl_open,
  input  logic [NUM_SLOTS-1:0]   card_present,
  output logic [31:0]            status,
  output logic [2*NUM_SLOTS-1:0] slot_state,
  output logic [2:0]             bus_speed,
  output logic                   cmd_done
);

  localparam logic [1:0] ST_PWR = 2'b01;
  localparam logic [1:0] ST_ENA = 2'b10;
  localparam logic [1:0] ST_DIS = 2'b11;
  localparam logic [2:0] SPD_MAX = 3'd4;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      cmd;
  logic [2:0]       err;
  logic [2:0]       err_nxt;
  logic [1:0]       st [NUM_SLOTS];

  wire [7:0] tgt    = cmd[15:8];
  wire [1:0] req    = cmd[1:0];
  wire       is_spd = cmd[6];
  wire       tgt_ok = (tgt != 8'd0) && (tgt <= 8'(NUM_SLOTS));
  wire       last   = busy && (cnt == CNT_W'(1));

  logic sel_mrl, sel_pres, any_en;

  always_comb begin
    sel_mrl  = 1'b0;
    sel_pres = 1'b0;
    any_en   = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (tgt == 8'(i + 1)) begin
        sel_mrl  = mrl_open[i];
        sel_pres = card_present[i];
      end
      if (st[i] == ST_ENA) any_en = 1'b1;
    end
  end

  always_comb begin
    err_nxt = 3'b000;
    if (is_spd) begin
      if (cmd[2:0] > SPD_MAX || any_en) err_nxt = 3'b100;
    end else if (!tgt_ok || req == 2'b00) begin
      err_nxt = 3'b010;
    end else if (sel_mrl) begin
      err_nxt = 3'b001;
    end else if (!sel_pres && req != ST_DIS) begin
      err_nxt = 3'b010;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      cmd       <= '0;
      err       <= '0;
      bus_speed <= '0;
      cmd_done  <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      if (!busy && wr_en) begin
        busy <= 1'b1;
        cnt  <= (busy_cycles == '0) ? CNT_W'(1) : busy_cycles;
        cmd  <= wr_data;
        err  <= '0;
      end else if (last) begin
        busy     <= 1'b0;
        cmd_done <= 1'b1;
        err      <= err_nxt;
        if (err_nxt == 3'b000 && is_spd) bus_speed <= cmd[2:0];
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        st[g] <= ST_DIS;
      else if (last && err_nxt == 3'b000 && !is_spd && tgt == 8'(g + 1))
        st[g] <= req;
    end
    assign slot_state[2*g +: 2] = st[g];
  end

  assign status = {12'd0, err, busy, 13'd0, bus_speed};

endmodule

// File: rtl/hpc_cmd_engine_chk.sv
module hpc_cmd_engine_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [31:0]            status,
  input logic [2*NUM_SLOTS-1:0] slot_state,
  input logic [2:0]             bus_speed,
  input logic                   cmd_done
);

  AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status[19:17])); // R3

  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[16]) |-> cmd_done); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done); // R3

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !status[16]); // R2

  AST_STATE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slot_state) |-> cmd_done); // R4

  AST_SPEED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_speed) |-> cmd_done); // R8

  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && status[19:17] != 3'b000) |-> ($stable(slot_state) && $stable(bus_speed))); // R5

  AST_SPEED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_speed <= 3'd4); // R9

endmodule

bind hpc_cmd_engine hpc_cmd_engine_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .slot_state(slot_state),
  .bus_speed(bus_speed), .cmd_done(cmd_done)
);

// File: tb/test_hpc_cmd_engine.sv
module test_hpc_cmd_engine;
  localparam int NS = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [CW-1:0] busy_cycles = '0;
  logic [NS-1:0] mrl_open = '0;
  logic [NS-1:0] card_present = 4'b0111;
  logic [31:0]   status;
  logic [2*NS-1:0] slot_state;
  logic [2:0]    bus_speed;
  logic          cmd_done;

  hpc_cmd_engine #(.NUM_SLOTS(NS), .CNT_W(CW)) i_hpc_cmd_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .busy_cycles(busy_cycles), .mrl_open(mrl_open), .card_present(card_present),
    .status(status), .slot_state(slot_state), .bus_speed(bus_speed),
    .cmd_done(cmd_done)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [2:0]      err;
    logic [2*NS-1:0] st;
    logic [2:0]      spd;
    string           tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [1:0] m_st [NS];
  logic [2:0] m_spd;
  logic [2:0] last_err;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*NS-1:0] pack_st();
    logic [2*NS-1:0] p;
    for (int i = 0; i < NS; i++) p[2*i +: 2] = m_st[i];
    return p;
  endfunction

  always @(negedge clk) begin
    if (rst_n && cmd_done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R3 unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(status[19:17] == e.err, {e.tag, " error bits"}, status[19:17], e.err);
        chk(slot_state == e.st, {e.tag, " slot state"}, slot_state, e.st);
        chk(bus_speed == e.spd && status[2:0] == e.spd, {e.tag, " speed"}, bus_speed, e.spd);
      end
    end
  end

  task automatic send(input logic [31:0] c, input int n, input string tag,
                      input bit intrude = 1'b0);
    exp_t e;
    logic [7:0] tgt;
    logic [1:0] req;
    logic any_en;
    int cnt;
    int want;
    tgt = c[15:8];
    req = c[1:0];
    e.err = 3'b000;
    if (c[6]) begin
      any_en = 1'b0;
      for (int i = 0; i < NS; i++) if (m_st[i] == 2'b10) any_en = 1'b1;
      if (c[2:0] > 3'd4 || any_en) e.err = 3'b100;
      else m_spd = c[2:0];
    end else if (tgt == 0 || tgt > NS || req == 2'b00) begin
      e.err = 3'b010;
    end else if (mrl_open[tgt-1]) begin
      e.err = 3'b001;
    end else if (!card_present[tgt-1] && req != 2'b11) begin
      e.err = 3'b010;
    end else begin
      m_st[tgt-1] = req;
    end
    e.st  = pack_st();
    e.spd = m_spd;
    e.tag = tag;
    q.push_back(e);
    last_err = e.err;
    busy_cycles = CW'(n);
    wr_data = c;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    cnt = 0;
    while (status[16] && cnt < 300) begin
      cnt++;
      if (intrude && cnt == 1) begin
        wr_data = 32'h0000_0202;
        wr_en = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    want = (n == 0) ? 1 : n;
    chk(cnt == want, "R2 busy length", cnt, want);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cycles, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) m_st[i] = 2'b11;
    m_spd = 3'd0;
    repeat (3) @(negedge clk);
    chk(slot_state == {NS{2'b11}}, "R1 reset slots", slot_state, {NS{2'b11}});
    chk(bus_speed == 3'd0, "R1 reset speed", bus_speed, 0);
    chk(status[19:16] == 4'd0 && !cmd_done, "R1 reset status", status[19:16], 0);
    rst_n = 1'b1;
    @(negedge clk);

    send(32'h0000_0102, 3, "R4 enable slot0");
    send(32'h0000_0043, 2, "R9 speed while enabled");
    repeat (3) @(negedge clk);
    chk(status[19:17] == last_err, "R3 error held", status[19:17], last_err);
    send(32'h0000_0103, 0, "R4 disable slot0");
    send(32'h0000_0043, 1, "R8 speed 3");
    send(32'h0000_0045, 2, "R9 speed code 5");
    send(32'h0000_0002, 2, "R5 target zero");
    send(32'h0000_0502, 2, "R5 target above count");
    send(32'h0000_0200, 2, "R5 state code 00");
    mrl_open = 4'b1010;
    send(32'h0000_0202, 4, "R6 latch open");
    send(32'h0000_0200, 2, "R10 code 00 beats latch");
    send(32'h0000_0401, 2, "R10 latch beats empty");
    mrl_open = 4'b0000;
    send(32'h0000_0401, 2, "R7 power-only empty");
    send(32'h0000_0403, 2, "R7 disable empty");
    send(32'h0000_0301, 5, "R2 write during busy", 1'b1);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R2 ignored write no completion", q.size(), 0);
    chk(slot_state[3:2] == 2'b11, "R2 ignored write slot1", slot_state[3:2], 2'b11);
    send(32'h0000_0044, 2, "R9 speed 4 boundary");
    send(32'h0000_0202, 2, "R4 enable slot1");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R3 all completions seen", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule